// File: doc/BRIEF.md
# Multi-Stream Sequential Prefetch Buffers

This block sits beside a cache and follows several sequential miss streams at the same time. Each stream buffer keeps a short window of upcoming line addresses. Each slot in the window has two flags: one says the line has been requested from memory, the other says its fill has come back. Every demand miss from the cache is compared against every slot of every buffer in the same cycle.

On a hit the block answers "hit", together with whether the line is already present. It then slides that buffer forward past the hit line and requests the lines that enter the tail of the window. A hit deeper in the window skips the lines in front of it. On a miss in all buffers, the least-recently-used buffer is given to a new stream whose window starts at the line after the miss. Line requests leave through a small queue with a valid/ready handshake. Fills come back as line addresses. Only addresses and flags are stored, never data. No stream generates a line outside the 4 KiB page in which it started.

Top module: `sbp_top`

## Requirements
- R1: After reset `respValid` and `pfValid` are 0 and every buffer is empty, so the first demand miss is reported as a miss.
- R2: A demand miss with `missValid`=1 gives `respValid`=1 exactly one cycle later. If no valid slot of any buffer holds `missAddr`, `respHit`=0 and a buffer is allocated whose window is lines `missAddr`+1 up to `missAddr`+DEPTH.
- R3: A hit on the first slot (line X) gives `respHit`=1 and slides the window by one. The new tail line X+DEPTH is requested afterwards.
- R4: A hit on slot k (line X+k, 0 ≤ k < DEPTH) slides the window by k+1. The skipped lines are dropped, and the freed tail slots are requested in ascending address order.
- R5: All slots of all buffers are compared in parallel, and the lowest-numbered buffer wins when several match. Interleaved streams each keep their own buffer.
- R6: Allocation takes the least-recently-used buffer, where a hit or an allocation counts as a use. After reset the highest-numbered buffer is the least recent.
- R7: `respReady`=1 only on a hit whose line was requested and whose fill (`fillValid` with `fillAddr` equal to the line) arrived in an earlier cycle. A hit on a line still outstanding or not yet requested gives `respHit`=1 and `respReady`=0. A fill that matches no outstanding slot changes nothing.
- R8: At most one line is requested per cycle, and only in cycles with `missValid`=0 while the queue has space. The request is chosen by lowest buffer number, then by lowest slot. The queue presents requests in order on `pfAddr` while `pfValid`=1 and drops the head when `pfReady`=1.
- R9: A page is a run of 2^PAGE_LINES_LOG2 lines that share their upper address bits (64 lines by default, which is 4 KiB of 64-byte lines). No line outside the page of the miss that started a stream is ever requested or matched for that stream.
- R10: While `pfReady`=0 the head of the queue stays on `pfAddr` unchanged. No pending line is lost, and requests resume in order once `pfReady` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| missValid | input | 1 | Demand miss lookup this cycle |
| missAddr | input | LINE_AW | Line address of the demand miss |
| respValid | output | 1 | Lookup result is valid (one cycle after the miss) |
| respHit | output | 1 | Line was found in a stream buffer |
| respReady | output | 1 | Found line has already been filled |
| pfValid | output | 1 | A line request is waiting in the queue |
| pfAddr | output | LINE_AW | Line address of the request at the queue head |
| pfReady | input | 1 | Memory side accepts the head request |
| fillValid | input | 1 | A requested line has returned |
| fillAddr | input | LINE_AW | Line address of the returned fill |

## Verification
The hardest case to reach from the ports is a hit on a slot whose line has not yet been filled. Lines are requested only in idle cycles, so the stimulus sends an allocating miss and a hit on the next line in consecutive cycles, with no idle cycle between them. The deep-slot skip and the page-end window need an idle, fully filled buffer. These are set up by quiet periods before the hit, and by a miss two lines from the end of a page. Queue backpressure is held long enough to fill the queue, so that the order after release can be compared with the reference model on every cycle.

// File: rtl/sbp_pkg.sv
package sbp_pkg;
  // width of every index carried in the strobe bundle (up to 16 buffers, 15 slots)
  localparam int IDX_W = 4;

  typedef struct packed {
    logic             advance;   // slide a buffer after a hit
    logic [IDX_W-1:0] advBuf;
    logic [IDX_W-1:0] advStep;   // hit slot + 1
    logic             alloc;     // restart a buffer on a new stream
    logic [IDX_W-1:0] allocBuf;
    logic             issue;     // mark one slot as requested
    logic [IDX_W-1:0] issueBuf;
    logic [IDX_W-1:0] issueSlot;
  } sbpStrobe_t;
endpackage

// File: rtl/sbp_req_fifo.sv
module sbp_req_fifo #(
  parameter int W     = 20,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pushEn,
  input  logic [W-1:0] pushData,
  input  logic         popEn,
  output logic         full,
  output logic         outValid,
  output logic [W-1:0] outData
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full     = (count == CNT_W'(DEPTH));
  assign outValid = (count != '0);
  assign outData  = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (pushEn) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (pushEn) wrPtr <= nextPtr(wrPtr);
      if (popEn)  rdPtr <= nextPtr(rdPtr);
      case ({pushEn, popEn})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pushEn |-> !full);
  assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    popEn |-> outValid);
endmodule

// File: rtl/sbp_datapath.sv
module sbp_datapath
  import sbp_pkg::*;
#(
  parameter int LINE_AW         = 20,
  parameter int NUM_BUF         = 4,
  parameter int DEPTH           = 4,
  parameter int PAGE_LINES_LOG2 = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       missValid,
  input  logic [LINE_AW-1:0]         missAddr,
  input  logic                       fillValid,
  input  logic [LINE_AW-1:0]         fillAddr,
  input  sbpStrobe_t                 strobe,
  output logic [NUM_BUF*DEPTH-1:0]   slotHit,
  output logic [NUM_BUF*DEPTH-1:0]   slotRdy,
  output logic [NUM_BUF*DEPTH-1:0]   needReq,
  output logic [LINE_AW-1:0]         issueAddr
);
  localparam int PAGE_W = LINE_AW - PAGE_LINES_LOG2;
  localparam int BUF_W  = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1;
  localparam int SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [LINE_AW-1:0] baseAll [NUM_BUF];

  for (genvar b = 0; b < NUM_BUF; b++) begin : g_buf
    logic               bufValidQ;
    logic [LINE_AW-1:0] baseQ;
    logic [PAGE_W-1:0]  pageQ;
    logic [DEPTH-1:0]   reqQ, rdyQ, slotValid, fillHit;
    logic [LINE_AW-1:0] slotAddr [DEPTH];
    logic               isAlloc, isAdv, isIssue;

    assign baseAll[b] = baseQ;
    assign isAlloc    = strobe.alloc   && (strobe.allocBuf == IDX_W'(b));
    assign isAdv      = strobe.advance && (strobe.advBuf   == IDX_W'(b));
    assign isIssue    = strobe.issue   && (strobe.issueBuf == IDX_W'(b));

    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
      assign slotAddr[s]  = baseQ + LINE_AW'(s);
      assign slotValid[s] = bufValidQ &&
                            (slotAddr[s][LINE_AW-1:PAGE_LINES_LOG2] == pageQ);
      assign fillHit[s]   = fillValid && slotValid[s] && reqQ[s] && !rdyQ[s] &&
                            (slotAddr[s] == fillAddr);
      assign slotHit[b*DEPTH+s] = missValid && slotValid[s] && (slotAddr[s] == missAddr);
      assign slotRdy[b*DEPTH+s] = rdyQ[s];
      assign needReq[b*DEPTH+s] = slotValid[s] && !reqQ[s];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bufValidQ <= 1'b0;
        baseQ     <= '0;
        pageQ     <= '0;
        reqQ      <= '0;
        rdyQ      <= '0;
      end else if (isAlloc) begin
        bufValidQ <= 1'b1;
        baseQ     <= missAddr + LINE_AW'(1);
        pageQ     <= missAddr[LINE_AW-1:PAGE_LINES_LOG2];
        reqQ      <= '0;
        rdyQ      <= '0;
      end else if (isAdv) begin
        baseQ <= baseQ + LINE_AW'(strobe.advStep);
        reqQ  <= reqQ >> strobe.advStep;
        rdyQ  <= (rdyQ | fillHit) >> strobe.advStep;
      end else begin
        rdyQ <= rdyQ | fillHit;
        if (isIssue) reqQ[strobe.issueSlot[SLOT_W-1:0]] <= 1'b1;
      end
    end

    assert_ready_after_request_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rdyQ & ~reqQ) == '0);
    assert_issue_inside_page_R9: assert property (@(posedge clk) disable iff (!rst_n)
      isIssue |-> (slotValid[strobe.issueSlot[SLOT_W-1:0]] &&
                   !reqQ[strobe.issueSlot[SLOT_W-1:0]]));
  end

  assign issueAddr = baseAll[strobe.issueBuf[BUF_W-1:0]] + LINE_AW'(strobe.issueSlot);
endmodule

// File: rtl/sbp_ctrl.sv
module sbp_ctrl
  import sbp_pkg::*;
#(
  parameter int NUM_BUF = 4,
  parameter int DEPTH   = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     missValid,
  input  logic [NUM_BUF*DEPTH-1:0] slotHit,
  input  logic [NUM_BUF*DEPTH-1:0] slotRdy,
  input  logic [NUM_BUF*DEPTH-1:0] needReq,
  input  logic                     fifoFull,
  output sbpStrobe_t               strobe,
  output logic                     respValid,
  output logic                     respHit,
  output logic                     respReady
);
  logic [IDX_W-1:0]   age [NUM_BUF];
  logic [NUM_BUF-1:0] victimVec;
  logic [IDX_W-1:0]   victimBuf, hitBuf, hitSlot, reqBuf, reqSlot, touchBuf, ageTouch;
  logic               hitAny, hitRdy, needAny;

  // descending loops: the last match written is the lowest buffer / slot
  always_comb begin
    hitAny = 1'b0; hitRdy = 1'b0; hitBuf = '0; hitSlot = '0;
    needAny = 1'b0; reqBuf = '0; reqSlot = '0;
    for (int b = NUM_BUF - 1; b >= 0; b--) begin
      for (int s = DEPTH - 1; s >= 0; s--) begin
        if (slotHit[b*DEPTH+s]) begin
          hitAny  = 1'b1;
          hitBuf  = IDX_W'(b);
          hitSlot = IDX_W'(s);
          hitRdy  = slotRdy[b*DEPTH+s];
        end
        if (needReq[b*DEPTH+s]) begin
          needAny = 1'b1;
          reqBuf  = IDX_W'(b);
          reqSlot = IDX_W'(s);
        end
      end
    end
  end

  always_comb begin
    victimBuf = '0;
    for (int b = 0; b < NUM_BUF; b++) begin
      victimVec[b] = (age[b] == IDX_W'(NUM_BUF - 1));
      if (victimVec[b]) victimBuf = IDX_W'(b);
    end
  end

  assign touchBuf = hitAny ? hitBuf : victimBuf;

  always_comb begin
    ageTouch = '0;
    for (int b = 0; b < NUM_BUF; b++)
      if (IDX_W'(b) == touchBuf) ageTouch = age[b];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NUM_BUF; b++) age[b] <= IDX_W'(b);
    end else if (missValid) begin
      for (int b = 0; b < NUM_BUF; b++) begin
        if (IDX_W'(b) == touchBuf)  age[b] <= '0;
        else if (age[b] < ageTouch) age[b] <= age[b] + 1'b1;
      end
    end
  end

  always_comb begin
    strobe           = '0;
    strobe.advance   = missValid && hitAny;
    strobe.advBuf    = hitBuf;
    strobe.advStep   = hitSlot + 1'b1;
    strobe.alloc     = missValid && !hitAny;
    strobe.allocBuf  = victimBuf;
    strobe.issue     = !missValid && needAny && !fifoFull;
    strobe.issueBuf  = reqBuf;
    strobe.issueSlot = reqSlot;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      respValid <= 1'b0;
      respHit   <= 1'b0;
      respReady <= 1'b0;
    end else begin
      respValid <= missValid;
      respHit   <= missValid && hitAny;
      respReady <= missValid && hitAny && hitRdy;
    end
  end

  assert_lru_single_victim_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(victimVec));
  assert_ready_implies_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    respReady |-> (respHit && respValid));
endmodule

// File: rtl/sbp_top.sv
module sbp_top
  import sbp_pkg::*;
#(
  parameter int LINE_AW         = 20,
  parameter int NUM_BUF         = 4,
  parameter int DEPTH           = 4,
  parameter int PAGE_LINES_LOG2 = 6,
  parameter int QUEUE_DEPTH     = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               missValid,
  input  logic [LINE_AW-1:0] missAddr,
  output logic               respValid,
  output logic               respHit,
  output logic               respReady,
  output logic               pfValid,
  output logic [LINE_AW-1:0] pfAddr,
  input  logic               pfReady,
  input  logic               fillValid,
  input  logic [LINE_AW-1:0] fillAddr
);
  sbpStrobe_t                strobe;
  logic [NUM_BUF*DEPTH-1:0]  slotHit, slotRdy, needReq;
  logic [LINE_AW-1:0]        issueAddr;
  logic                      fifoFull;

  sbp_ctrl #(.NUM_BUF(NUM_BUF), .DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .missValid(missValid),
    .slotHit(slotHit), .slotRdy(slotRdy), .needReq(needReq), .fifoFull(fifoFull),
    .strobe(strobe), .respValid(respValid), .respHit(respHit), .respReady(respReady)
  );

  sbp_datapath #(.LINE_AW(LINE_AW), .NUM_BUF(NUM_BUF), .DEPTH(DEPTH),
                 .PAGE_LINES_LOG2(PAGE_LINES_LOG2)) dp_i (
    .clk(clk), .rst_n(rst_n), .missValid(missValid), .missAddr(missAddr),
    .fillValid(fillValid), .fillAddr(fillAddr), .strobe(strobe),
    .slotHit(slotHit), .slotRdy(slotRdy), .needReq(needReq), .issueAddr(issueAddr)
  );

  sbp_req_fifo #(.W(LINE_AW), .DEPTH(QUEUE_DEPTH)) fifo_i (
    .clk(clk), .rst_n(rst_n), .pushEn(strobe.issue), .pushData(issueAddr),
    .popEn(pfValid && pfReady), .full(fifoFull), .outValid(pfValid), .outData(pfAddr)
  );
endmodule

// File: tb/sbp_top_tb.sv
module sbp_top_tb_top;
  localparam int AW = 20, NB = 4, D = 4, PL = 6, QD = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          missValid = 1'b0, pfReady = 1'b1, fillValid = 1'b0;
  logic [AW-1:0] missAddr = '0, fillAddr = '0;
  logic          respValid, respHit, respReady, pfValid;
  logic [AW-1:0] pfAddr;

  always #5 clk = ~clk;

  sbp_top #(.LINE_AW(AW), .NUM_BUF(NB), .DEPTH(D), .PAGE_LINES_LOG2(PL),
            .QUEUE_DEPTH(QD)) dut_i (.*);

  int nChecks = 0, nFail = 0, cyc = 0;

  // ---------------- behavioural reference ----------------
  bit    mValid [NB];
  int    mBase [NB], mPage [NB];
  bit    mReq [NB][D], mRdy [NB][D];
  int    lru [$];            // front = most recent
  int    mq [$];             // request queue
  int    outst [$];          // popped, awaiting fill
  int    popLog [$];
  bit    eRespV, eRespH, eRespR;
  string eTag = "R2";

  function automatic bit slotOk(int b, int s);
    return mValid[b] && (((mBase[b] + s) >> PL) == mPage[b]);
  endfunction

  task automatic touch(int b);
    foreach (lru[i]) if (lru[i] == b) begin lru.delete(i); break; end
    lru.push_front(b);
  endtask

  task automatic modelReset();
    lru = {};
    for (int b = 0; b < NB; b++) begin
      mValid[b] = 0; mBase[b] = 0; mPage[b] = 0; lru.push_back(b);
      for (int s = 0; s < D; s++) begin mReq[b][s] = 0; mRdy[b][s] = 0; end
    end
    mq = {}; outst = {}; eRespV = 0; eRespH = 0; eRespR = 0;
  endtask

  task automatic modelStep();
    int hb = -1, hs = -1;
    bit full = (mq.size() == QD);
    bit doPop = (mq.size() > 0) && pfReady;
    bit done = 0;
    if (missValid)
      for (int b = 0; b < NB && hb < 0; b++)
        for (int s = 0; s < D; s++)
          if (slotOk(b, s) && mBase[b] + s == int'(missAddr)) begin hb = b; hs = s; end
    eRespV = missValid; eRespH = (hb >= 0); eRespR = (hb >= 0) && mRdy[hb][hs];
    eTag = (hb < 0) ? "R2" : (hs == 0 ? "R3" : "R4");
    if (fillValid)
      for (int b = 0; b < NB; b++)
        for (int s = 0; s < D; s++)
          if (slotOk(b, s) && mReq[b][s] && !mRdy[b][s] && mBase[b] + s == int'(fillAddr))
            mRdy[b][s] = 1;
    if (missValid) begin
      if (hb >= 0) begin
        int k = hs + 1;
        for (int s = 0; s < D; s++) begin
          mReq[hb][s] = (s + k < D) ? mReq[hb][s+k] : 0;
          mRdy[hb][s] = (s + k < D) ? mRdy[hb][s+k] : 0;
        end
        mBase[hb] += k;
        touch(hb);
      end else begin
        int v = lru[$];
        mValid[v] = 1; mBase[v] = int'(missAddr) + 1; mPage[v] = int'(missAddr) >> PL;
        for (int s = 0; s < D; s++) begin mReq[v][s] = 0; mRdy[v][s] = 0; end
        touch(v);
      end
    end else if (!full) begin
      for (int b = 0; b < NB && !done; b++)
        for (int s = 0; s < D && !done; s++)
          if (slotOk(b, s) && !mReq[b][s]) begin
            mReq[b][s] = 1; mq.push_back(mBase[b] + s); done = 1;
          end
    end
    if (doPop) begin
      int a = mq.pop_front();
      outst.push_back(a); popLog.push_back(a);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) modelReset(); else modelStep();
  end

  // ---------------- checking ----------------
  task automatic chk(bit ok, string tag, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk(respValid == eRespV, eTag, respValid, eRespV);
      if (eRespV) begin
        chk(respHit == eRespH, eTag, respHit, eRespH);
        chk(respReady == eRespR, "R7", respReady, eRespR);
      end
      chk(pfValid == (mq.size() > 0), "R8", pfValid, mq.size() > 0);
      if (mq.size() > 0) chk(pfAddr == AW'(mq[0]), "R8", pfAddr, mq[0]);
    end
  end

  // fills: outstanding lines come back every other cycle, plus a stray fill now and then
  always @(negedge clk) begin
    if (!rst_n) fillValid <= 1'b0;
    else if (outst.size() > 0 && cyc % 2 == 0) begin
      fillValid <= 1'b1; fillAddr <= AW'(outst.pop_front());
    end else if (cyc % 17 == 0) begin
      fillValid <= 1'b1; fillAddr <= 20'hFFFF0;   // R7: matches nothing
    end else fillValid <= 1'b0;
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic miss(int a);
    @(negedge clk); missValid = 1'b1; missAddr = AW'(a);
    @(negedge clk); missValid = 1'b0;
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > 100000) begin
      nChecks++; nFail++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  initial begin
    int idx, headAddr;
    bit found;
    modelReset();
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk(respValid == 0, "R1", respValid, 0);
    chk(pfValid == 0, "R1", pfValid, 0);

    // R9: stream started two lines before the page end has a one-line window
    idx = popLog.size();
    miss('h13E);
    chk(respValid && !respHit, "R1", respHit, 0);
    idle(10);
    chk(popLog.size() - idx == 1, "R9", popLog.size() - idx, 1);
    if (popLog.size() > idx) chk(popLog[idx] == 'h13F, "R9", popLog[idx], 'h13F);

    // R2/R3: new stream, then head hit with fills back
    miss('h200);
    chk(respValid && !respHit, "R2", respHit, 0);
    idle(14);
    miss('h201);
    chk(respHit && respReady, "R3", {respHit, respReady}, 3);
    idle(8);
    // R4: window is 0x202..0x205, hit on slot 2 skips three lines
    idx = popLog.size();
    miss('h204);
    chk(respHit == 1, "R4", respHit, 1);
    idle(10);
    chk(popLog.size() - idx == 3, "R4", popLog.size() - idx, 3);
    if (popLog.size() - idx >= 3) begin
      chk(popLog[idx] == 'h206, "R4", popLog[idx], 'h206);
      chk(popLog[idx+2] == 'h208, "R4", popLog[idx+2], 'h208);
    end

    // R7: hit in the very next cycle, before any request could leave
    @(negedge clk); missValid = 1'b1; missAddr = 'h300;
    @(negedge clk); missAddr = 'h301;
    @(negedge clk); missValid = 1'b0;
    chk(respHit == 1 && respReady == 0, "R7", {respHit, respReady}, 2);
    idle(12);

    // R5: two interleaved streams
    miss('h400); miss('h800);
    idle(16);
    for (int i = 1; i <= 2; i++) begin
      miss('h400 + i);
      chk(respHit && respReady, "R5", {respHit, respReady}, 3);
      miss('h800 + i);
      chk(respHit && respReady, "R5", {respHit, respReady}, 3);
      idle(6);
    end

    // R6: least recently used buffer is the one replaced
    miss('h1000); miss('h2000); miss('h3000); miss('h4000);
    miss('h1001);
    chk(respHit == 1, "R6", respHit, 1);
    miss('h5000);           // replaces the 0x2000 stream
    miss('h1002);
    chk(respHit == 1, "R6", respHit, 1);
    miss('h2001);
    chk(respValid && !respHit, "R6", respHit, 0);
    idle(20);

    // R10: backpressure holds the head, nothing is lost afterwards
    pfReady = 1'b0;
    miss('h6000);
    idle(3);
    headAddr = int'(pfAddr);
    idle(10);
    chk(pfValid == 1, "R10", pfValid, 1);
    chk(pfAddr == AW'(headAddr), "R10", pfAddr, headAddr);
    pfReady = 1'b1;
    idle(20);
    found = 0;
    foreach (popLog[i]) if (popLog[i] == 'h6004) found = 1;
    chk(found, "R10", found, 1);

    // mixed traffic against the reference model
    begin
      int cur [5];
      for (int s = 0; s < 5; s++) cur[s] = 'h10000 * (s + 1) + 'h8000;
      for (int n = 0; n < 600; n++) begin
        @(negedge clk);
        pfReady = ($urandom_range(3, 0) != 0);
        if ($urandom_range(1, 0) == 1) begin
          int s = $urandom_range(4, 0);
          missValid = 1'b1;
          missAddr = AW'(cur[s] + $urandom_range(2, 0));
          cur[s] = int'(missAddr) + 1;
          if ($urandom_range(15, 0) == 0) cur[s] += 'h20;
        end else missValid = 1'b0;
      end
      @(negedge clk); missValid = 1'b0; pfReady = 1'b1;
      idle(30);
    end
    finishRun();
  end
endmodule